// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits on the host side of an 8-bit NAND flash bus and turns simple user requests into correctly levelled bus cycles. Each request carries an opcode and the fields it needs. A command request issues one command byte. An address request issues a whole address sequence of four or five bytes. A program-data request writes one data byte, and a read request fetches one byte from the device. Longer transfers are built by issuing requests back to back. The block drives the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins, and splits the data bus into an output byte, an output enable and an input byte, which are joined into a tri-state pad outside the block.

The low and high widths of the strobes are counted in system clocks. Each width comes from its own configuration input, and a value of zero is treated as one clock. While a request is being carried out, a busy flag is high and new requests are refused. A byte read from the device is delivered on a data output together with a one-clock valid flag.

Top module: `nand_bus_seq`

## Requirements
- R1: A command request (op code 0) issues one write strobe with ce_n=0, cle=1, ale=0 and re_n=1, and `req_cmd` is on io_out when we_n rises.
- R2: An address request (op code 1) with cfg_five_addr=0 issues four write strobes with ce_n=0, ale=1, cle=0 and re_n=1. Byte k on io_out is req_addr[8k+7:8k], so the lowest byte (the column bytes) goes first.
- R3: With cfg_five_addr=1, an address request issues five such strobes, and the fifth carries req_addr[39:32].
- R4: A data-input request (op code 2) issues one write strobe with cle=0, ale=0, re_n=1 and ce_n=0, and `req_wdata` is on io_out when we_n rises.
- R5: A read request (op code 3) issues one read-strobe pulse with cle=0, ale=0, we_n=1 and ce_n=0. The io_in value present in the last low clock of re_n is captured, and it appears on rd_data with rd_valid high for exactly the one clock that follows the rise of re_n.
- R6: io_oe is high only while a command, address or data-input request is in progress. It is low whenever re_n is low, and it is low for at least one clock before re_n falls.
- R7: Every low pulse of we_n or re_n lasts max(cfg_low_cnt,1) clocks. Every high interval after a rise lasts max(cfg_high_cnt,1) clocks.
- R8: busy rises in the clock after a request is accepted. It stays high for exactly (1 if read else 0) + bytes×(low+high) clocks. A req_valid seen while busy is high starts nothing.
- R9: While idle (and after reset), busy=0, ce_n=1, we_n=1, re_n=1, cle=0, ale=0 and io_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_op | input | 2 | 0 command, 1 address, 2 data in, 3 data out |
| req_cmd | input | 8 | Command byte |
| req_addr | input | 40 | Address, byte 0 sent first |
| req_wdata | input | 8 | Byte to program |
| cfg_five_addr | input | 1 | 1 selects five address bytes, 0 selects four |
| cfg_low_cnt | input | 4 | Strobe low width in clocks (0 means 1) |
| cfg_high_cnt | input | 4 | Strobe high width in clocks (0 means 1) |
| busy | output | 1 | Request in progress |
| rd_valid | output | 1 | rd_data valid for one clock |
| rd_data | output | 8 | Captured read byte |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Bus byte driven to the device |
| io_oe | output | 1 | Output enable for io_out |
| io_in | input | 8 | Bus byte returned by the device |

## Verification
When the high width is one clock, the cycle in which a read byte is flagged valid is also the last cycle of busy. The bench makes these two meet by running back-to-back reads with minimum widths, and it starts the next request in the first idle cycle. It then checks that each captured byte matches the device model's value for that read, and that the next request's strobes begin on time. The bench also raises req_valid while a long address sequence is in progress. It judges the refusal by checking that the strobe log holds only the original bytes and that busy stays low after the sequence ends.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam int DATA_W          = 8;
    localparam int ADDR_BYTES_MIN  = 4;
    localparam int ADDR_BYTES_MAX  = 5;
    localparam int ADDR_W          = DATA_W * ADDR_BYTES_MAX;
    localparam int IDX_W           = $clog2(ADDR_BYTES_MAX + 1);
    localparam int TCNT_W          = 4;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } nbs_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TURN = 2'd1,
        PH_LOW  = 2'd2,
        PH_HIGH = 2'd3
    } nbs_phase_e;

    typedef struct packed {
        nbs_op_e             op;
        logic [DATA_W-1:0]   cmd;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } nbs_req_t;

    typedef struct packed {
        logic ce_n;
        logic cle;
        logic ale;
        logic we_n;
        logic re_n;
        logic oe;
    } nbs_pins_t;

    // A programmed width of zero is raised to the one-clock minimum.
    function automatic logic [TCNT_W-1:0] eff_width(input logic [TCNT_W-1:0] v);
        return (v == '0) ? TCNT_W'(1) : v;
    endfunction

    function automatic logic [IDX_W-1:0] byte_count(input nbs_op_e op, input logic five);
        if (op != OP_ADDR) return IDX_W'(1);
        return five ? IDX_W'(ADDR_BYTES_MAX) : IDX_W'(ADDR_BYTES_MIN);
    endfunction

endpackage

// File: rtl/nbs_phase_timer.sv
module nbs_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt;

    // Loading len makes the phase last len clocks: len-1 down to 0.
    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= len - W'(1);
        else if (cnt != '0)    cnt <= cnt - W'(1);
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/nbs_byte_sel.sv
module nbs_byte_sel #(
    parameter int BW = 8,
    parameter int NB = 5,
    parameter int IW = 3
) (
    input  logic [BW*NB-1:0] word,
    input  logic [IW-1:0]    idx,
    output logic [BW-1:0]    sel
);
    logic [BW-1:0] lanes [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = word[g*BW +: BW];
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < NB; i++) begin
            if (idx == IW'(i)) sel = lanes[i];
        end
    end
endmodule

// File: rtl/nbs_rd_capture.sv
module nbs_rd_capture #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample,
    input  logic [BW-1:0] din,
    output logic [BW-1:0] dout,
    output logic          valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= sample;
            if (sample) dout <= din;
        end
    end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
    import nbs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [DATA_W-1:0]   req_cmd,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                cfg_five_addr,
    input  logic [TCNT_W-1:0]   cfg_low_cnt,
    input  logic [TCNT_W-1:0]   cfg_high_cnt,
    output logic                busy,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                ce_n,
    output logic                cle,
    output logic                ale,
    output logic                we_n,
    output logic                re_n,
    output logic [DATA_W-1:0]   io_out,
    output logic                io_oe,
    input  logic [DATA_W-1:0]   io_in
);
    nbs_phase_e         ph, ph_nxt;
    nbs_req_t           cur;
    nbs_op_e            in_op;
    logic [IDX_W-1:0]   byte_idx, nbytes;
    logic               byte_last;
    logic               accept, byte_adv, rd_edge;
    logic               tmr_load, tmr_last;
    logic [TCNT_W-1:0]  tmr_len, low_w, high_w;
    logic [DATA_W-1:0]  addr_byte, bus_byte;
    nbs_pins_t          pins;

    assign in_op     = nbs_op_e'(req_op);
    assign low_w     = eff_width(cfg_low_cnt);
    assign high_w    = eff_width(cfg_high_cnt);
    assign byte_last = (byte_idx == nbytes - IDX_W'(1));

    // Phase sequencing: TURN only for reads, then LOW/HIGH per byte.
    always_comb begin
        ph_nxt   = ph;
        accept   = 1'b0;
        byte_adv = 1'b0;
        rd_edge  = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = low_w;
        unique case (ph)
            PH_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (in_op == OP_READ) begin
                        ph_nxt = PH_TURN;
                    end else begin
                        ph_nxt   = PH_LOW;
                        tmr_load = 1'b1;
                    end
                end
            end
            PH_TURN: begin
                ph_nxt   = PH_LOW;
                tmr_load = 1'b1;
            end
            PH_LOW: begin
                if (tmr_last) begin
                    ph_nxt   = PH_HIGH;
                    tmr_load = 1'b1;
                    tmr_len  = high_w;
                    rd_edge  = (cur.op == OP_READ);
                end
            end
            PH_HIGH: begin
                if (tmr_last) begin
                    if (byte_last) begin
                        ph_nxt = PH_IDLE;
                    end else begin
                        ph_nxt   = PH_LOW;
                        tmr_load = 1'b1;
                        byte_adv = 1'b1;
                    end
                end
            end
            default: ph_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            cur      <= '0;
            byte_idx <= '0;
            nbytes   <= IDX_W'(1);
        end else begin
            ph <= ph_nxt;
            if (accept) begin
                cur.op    <= in_op;
                cur.cmd   <= req_cmd;
                cur.addr  <= req_addr;
                cur.wdata <= req_wdata;
                byte_idx  <= '0;
                nbytes    <= byte_count(in_op, cfg_five_addr);
            end else if (byte_adv) begin
                byte_idx <= byte_idx + IDX_W'(1);
            end
        end
    end

    nbs_phase_timer #(.W(TCNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .len  (tmr_len),
        .last (tmr_last)
    );

    nbs_byte_sel #(.BW(DATA_W), .NB(ADDR_BYTES_MAX), .IW(IDX_W)) u_addr_sel (
        .word (cur.addr),
        .idx  (byte_idx),
        .sel  (addr_byte)
    );

    nbs_rd_capture #(.BW(DATA_W)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .sample (rd_edge),
        .din    (io_in),
        .dout   (rd_data),
        .valid  (rd_valid)
    );

    // Pin levels decoded from the registered phase and request.
    always_comb begin
        pins.ce_n = (ph == PH_IDLE);
        pins.cle  = (ph != PH_IDLE) && (cur.op == OP_CMD);
        pins.ale  = (ph != PH_IDLE) && (cur.op == OP_ADDR);
        pins.we_n = !((ph == PH_LOW) && (cur.op != OP_READ));
        pins.re_n = !((ph == PH_LOW) && (cur.op == OP_READ));
        pins.oe   = (ph != PH_IDLE) && (cur.op != OP_READ);
        unique case (cur.op)
            OP_CMD:  bus_byte = cur.cmd;
            OP_ADDR: bus_byte = addr_byte;
            default: bus_byte = cur.wdata;
        endcase
    end

    assign busy   = (ph != PH_IDLE);
    assign ce_n   = pins.ce_n;
    assign cle    = pins.cle;
    assign ale    = pins.ale;
    assign we_n   = pins.we_n;
    assign re_n   = pins.re_n;
    assign io_oe  = pins.oe;
    assign io_out = pins.oe ? bus_byte : '0;

endmodule

// File: rtl/nbs_bus_checker.sv
module nbs_bus_checker
    import nbs_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [TCNT_W-1:0]  cfg_low_cnt,
    input logic               busy,
    input logic               rd_valid,
    input logic               ce_n,
    input logic               cle,
    input logic               ale,
    input logic               we_n,
    input logic               re_n,
    input logic               io_oe
);
    logic [TCNT_W:0] we_run, re_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run <= '0;
            re_run <= '0;
        end else begin
            we_run <= we_n ? '0 : we_run + 1'b1;
            re_run <= re_n ? '0 : re_run + 1'b1;
        end
    end

    AST_CMD_LEVELS: assert property (@(posedge clk) disable iff (rst)
        cle |-> (!ce_n && !ale && re_n));                                 // R1
    AST_ADDR_LEVELS: assert property (@(posedge clk) disable iff (rst)
        ale |-> (!ce_n && !cle && re_n));                                 // R2
    AST_WRITE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!ce_n && re_n && io_oe));                              // R4
    AST_READ_STROBE: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> (!ce_n && we_n && !cle && !ale && !io_oe));             // R5
    AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);                                          // R5
    AST_VALID_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (re_n && !$past(re_n)));                             // R5
    AST_OE_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        $fell(re_n) |-> !$past(io_oe));                                   // R6
    AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (we_run == {1'b0, eff_width(cfg_low_cnt)}));      // R7
    AST_RE_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(re_n) |-> (re_run == {1'b0, eff_width(cfg_low_cnt)}));      // R7
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ce_n && we_n && re_n && !io_oe && !cle && !ale));      // R9

endmodule

bind nand_bus_seq nbs_bus_checker u_bus_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_low_cnt (cfg_low_cnt),
    .busy        (busy),
    .rd_valid    (rd_valid),
    .ce_n        (ce_n),
    .cle         (cle),
    .ale         (ale),
    .we_n        (we_n),
    .re_n        (re_n),
    .io_oe       (io_oe)
);

// File: tb/nand_bus_seq_tb_top.sv
module nand_bus_seq_tb_top;
    import nbs_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [7:0] req_cmd = '0, req_wdata = '0;
    logic [39:0] req_addr = '0;
    logic cfg_five_addr = 1'b0;
    logic [3:0] cfg_low_cnt = 4'd1, cfg_high_cnt = 4'd1;
    logic busy, rd_valid, ce_n, cle, ale, we_n, re_n, io_oe;
    logic [7:0] rd_data, io_out;
    logic [7:0] io_in = '0;

    int n_checks = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    nand_bus_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_five_addr(cfg_five_addr), .cfg_low_cnt(cfg_low_cnt),
        .cfg_high_cnt(cfg_high_cnt), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    function automatic logic [7:0] flash_byte(input int k);
        return 8'((k * 37) + 11);
    endfunction

    function automatic int eff(input logic [3:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- bus monitor and device model ----------------
    int  we_ev, re_ev, busy_cyc, viol, rv_cnt, rd_k;
    int  we_run, re_run;
    logic [7:0] ev_byte [8];
    logic       ev_cle  [8];
    logic       ev_ale  [8];
    int         ev_low  [8];
    int         re_low  [8];
    logic [7:0] rv_data;
    logic prev_we = 1'b1, prev_re = 1'b1, prev_oe = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cyc++;
            if (!we_n && !(re_n && io_oe && !ce_n)) viol++;
            if (!re_n && !(we_n && !io_oe && !cle && !ale && !ce_n)) viol++;
            if (!re_n && prev_re && prev_oe) viol++;
            if (cle && ale) viol++;
            if (io_oe && !busy) viol++;
            if (!re_n) io_in = flash_byte(rd_k);
            if (we_n && !prev_we) begin
                if (we_ev < 8) begin
                    ev_byte[we_ev] = io_out;
                    ev_cle[we_ev]  = cle;
                    ev_ale[we_ev]  = ale;
                    ev_low[we_ev]  = we_run;
                end
                we_ev++;
            end
            if (re_n && !prev_re) begin
                if (re_ev < 8) re_low[re_ev] = re_run;
                re_ev++;
                rd_k++;
            end
            if (rd_valid) begin
                rv_cnt++;
                rv_data = rd_data;
            end
            we_run = we_n ? 0 : we_run + 1;
            re_run = re_n ? 0 : re_run + 1;
            prev_we = we_n;
            prev_re = re_n;
            prev_oe = io_oe;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    // ---------------- one request, fully checked ----------------
    task automatic run_req(input logic [1:0] op, input logic [7:0] cmd,
                           input logic [39:0] addr, input logic [7:0] wd,
                           input logic five, input logic [3:0] lo,
                           input logic [3:0] hi, input bit poke);
        int n, exp_busy, k0;
        logic [7:0] exp_b;
        while (busy) @(negedge clk);
        cfg_five_addr = five;
        cfg_low_cnt   = lo;
        cfg_high_cnt  = hi;
        req_op = op; req_cmd = cmd; req_addr = addr; req_wdata = wd;
        we_ev = 0; re_ev = 0; busy_cyc = 0; viol = 0; rv_cnt = 0;
        k0 = rd_k;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = (op == 2'd1) ? (five ? 5 : 4) : 1;
        exp_busy = ((op == 2'd3) ? 1 : 0) + n * (eff(lo) + eff(hi));
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_op    = 2'd3;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        #1;
        chk(busy_cyc == exp_busy, "R8 busy length", busy_cyc, exp_busy);
        chk(viol == 0, "R6 pin levels and bus turnaround", viol, 0);
        if (op == 2'd3) begin
            chk(we_ev == 0 && re_ev == 1, "R5 read strobe count", re_ev, 1);
            chk(rv_cnt == 1, "R5 valid pulses", rv_cnt, 1);
            chk(rv_data == flash_byte(k0), "R5 read data", rv_data, flash_byte(k0));
            chk(re_low[0] == eff(lo), "R7 re low width", re_low[0], eff(lo));
        end else begin
            chk(we_ev == n && re_ev == 0, "R2 R3 write strobe count", we_ev, n);
            chk(rv_cnt == 0, "R4 no read valid", rv_cnt, 0);
            for (int i = 0; i < n && i < 8; i++) begin
                exp_b = (op == 2'd0) ? cmd : (op == 2'd1) ? addr[8*i +: 8] : wd;
                if (op == 2'd0)
                    chk(ev_byte[i] == exp_b && ev_cle[i] && !ev_ale[i], "R1 command cycle", ev_byte[i], exp_b);
                else if (op == 2'd1)
                    chk(ev_byte[i] == exp_b && ev_ale[i] && !ev_cle[i], "R2 address byte order", ev_byte[i], exp_b);
                else
                    chk(ev_byte[i] == exp_b && !ev_ale[i] && !ev_cle[i], "R4 data input", ev_byte[i], exp_b);
                chk(ev_low[i] == eff(lo), "R7 we low width", ev_low[i], eff(lo));
            end
        end
        if (poke) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                chk(!busy && ce_n, "R8 request while busy ignored", busy, 0);
            end
        end
    endtask

    initial begin
        logic [1:0] op;
        logic [39:0] a;
        int n, ebusy;
        void'($urandom(32'd4242));
        rd_k = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && ce_n && we_n && re_n && !cle && !ale && !io_oe && !rd_valid,
            "R9 reset idle pins", {busy, ce_n, we_n, re_n, cle, ale, io_oe}, 7'b0111000);

        run_req(2'd0, 8'h70, '0, '0, 1'b0, 4'd1, 4'd1, 1'b0);                  // R1
        run_req(2'd1, 8'h00, 40'h55_44_33_22_11, '0, 1'b0, 4'd2, 4'd1, 1'b0);  // R2
        run_req(2'd1, 8'h00, 40'hA5_B4_C3_D2_E1, '0, 1'b1, 4'd1, 4'd3, 1'b0);  // R3
        run_req(2'd2, 8'h00, '0, 8'h3C, 1'b0, 4'd3, 4'd2, 1'b0);               // R4
        run_req(2'd3, 8'h00, '0, '0, 1'b0, 4'd0, 4'd0, 1'b0);                  // R5 R7 zero widths
        run_req(2'd3, 8'h00, '0, '0, 1'b0, 4'd1, 4'd1, 1'b0);                  // R5 back to back
        run_req(2'd3, 8'h00, '0, '0, 1'b0, 4'd1, 4'd1, 1'b0);
        run_req(2'd1, 8'h00, 40'h01_02_03_04_05, '0, 1'b1, 4'd3, 4'd3, 1'b1);  // R8 refusal
        run_req(2'd2, 8'h00, '0, 8'hFF, 1'b0, 4'd15, 4'd15, 1'b0);             // R7 widest

        for (int t = 0; t < 60; t++) begin
            op = 2'($urandom_range(0, 3));
            a  = {8'($urandom), 32'($urandom)};
            n  = (op == 2'd1) ? 5 : 1;
            ebusy = n * 2;
            run_req(op, 8'($urandom), a, 8'($urandom), 1'($urandom),
                    4'($urandom_range(0, 4)), 4'($urandom_range(0, 4)),
                    (op == 2'd1) && (ebusy >= 8) && ($urandom_range(0, 1) == 1));
        end

        @(negedge clk);
        chk(!busy && ce_n && !io_oe, "R9 idle after traffic", {busy, ce_n, io_oe}, 3'b010);
        summary();
        $finish;
    end
endmodule